// File: doc/BRIEF.md
# DC Fault Ride-Through Sequencer

This block is the supervisory state machine of a modular converter that has to survive a short circuit on its DC side without a breaker. Once per switching period it receives a strobe together with a sampled DC-link current code and a sampled DC-bus voltage code. An overcurrent does not latch the converter off. Instead the block steps through a fixed recovery sequence:
- it blocks gating;
- it waits for the bus to collapse;
- after one more period it lets the converter source a regulated fault current for a programmed number of periods;
- it blocks gating again so the faulted segment can be isolated;
- it returns to normal operation once the bus has been restored to the arm average voltage.

The block has three control outputs. The first enables gating. The second selects normal or fault-current modulation. The third tells the control loops which variable regulates current: in fault-current mode the duty cycle regulates current and the phase shift holds the arm voltage, and in normal mode the two roles are swapped. A status code reports the present phase.

Top module: `dcfrt_seq`

## Requirements
- R1: State changes only on clock edges where `period_tick` is high. With the strobe low, the outputs stay unchanged whatever the sample inputs do.
- R2: In normal operation (code 0), a strobe with `dc_current` strictly greater than `oc_limit` moves the block to code 1 (gating blocked). `gate_en` is low from the following clock on.
- R3: In normal operation, a strobe with `dc_current` equal to or below `oc_limit` leaves the block in code 0 with `gate_en` high.
- R4: In code 1, a strobe with `bus_volt` strictly below `safe_limit` moves the block to code 2 (arming, gating still blocked). Any other strobe keeps it in code 1.
- R5: Code 2 lasts exactly one period. The next strobe moves the block to code 3, where `gate_en`, `fault_mode` and `duty_ctrl_cur` are all high.
- R6: Code 3 lasts exactly `fault_periods` strobes, with a value of 0 treated as 1. The block then moves to code 4 with gating blocked. Overcurrent samples are ignored during code 3.
- R7: In code 4, a strobe with `bus_volt` at or above `arm_ref` and no overcurrent returns the block to code 0. A lower voltage keeps it in code 4.
- R8: In code 4, a strobe that carries an overcurrent moves the block to code 1 even if the bus voltage has already recovered.
- R9: A synchronous reset puts the block in code 0 with `gate_en` high, and `fault_mode` and `duty_ctrl_cur` low.
- R10: `fault_mode` and `duty_ctrl_cur` are high only in code 3. `gate_en` is high only in codes 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_tick | input | 1 | One-cycle strobe, once per switching period |
| dc_current | input | CUR_W | Sampled DC-link current code |
| bus_volt | input | VOLT_W | Sampled DC-bus voltage code |
| oc_limit | input | CUR_W | Overcurrent threshold |
| safe_limit | input | VOLT_W | Collapsed-bus threshold |
| fault_periods | input | CNT_W | Fault-current window length in periods |
| arm_ref | input | VOLT_W | Arm average voltage code, the recovery target |
| gate_en | output | 1 | Gating enable |
| fault_mode | output | 1 | Fault-current modulation selected |
| duty_ctrl_cur | output | 1 | 1: duty cycle regulates current; 0: phase shift regulates current |
| state_code | output | 3 | 0 normal, 1 blocked, 2 arming, 3 fault current, 4 isolating |

## Verification
The hardest situation to reach from the ports is a fresh overcurrent that arrives in the isolating phase at the same strobe as a bus voltage that already satisfies the recovery condition. Reaching it takes a complete trip, collapse, arming and timed fault window first. The bench therefore drives the whole sequence strobe by strobe, and at the isolating phase it presents the conflicting sample pair. It then repeats the full sequence while sweeping the window length, including zero, and sweeping each threshold across its boundary value.

// File: rtl/dcfrt_pkg.sv
package dcfrt_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_BLOCKED = 3'd1,
        ST_ARMING  = 3'd2,
        ST_FAULT   = 3'd3,
        ST_ISOLATE = 3'd4
    } frt_state_t;

    typedef struct packed {
        logic over_cur;
        logic bus_low;
        logic bus_ok;
    } frt_cond_t;

    typedef struct packed {
        logic gate_en;
        logic fault_mode;
        logic duty_ctrl_cur;
    } frt_ctrl_t;

    function automatic frt_ctrl_t ctrl_of(frt_state_t s);
        frt_ctrl_t c;
        c.gate_en       = (s == ST_NORMAL) || (s == ST_FAULT);
        c.fault_mode    = (s == ST_FAULT);
        c.duty_ctrl_cur = (s == ST_FAULT);
        return c;
    endfunction

endpackage

// File: rtl/dcfrt_cond.sv
module dcfrt_cond
    import dcfrt_pkg::*;
#(
    parameter int CUR_W  = 12,
    parameter int VOLT_W = 12
) (
    input  logic [CUR_W-1:0]  dc_current,
    input  logic [VOLT_W-1:0] bus_volt,
    input  logic [CUR_W-1:0]  oc_limit,
    input  logic [VOLT_W-1:0] safe_limit,
    input  logic [VOLT_W-1:0] arm_ref,
    output frt_cond_t         cond
);
    always_comb begin
        cond.over_cur = dc_current > oc_limit;
        cond.bus_low  = bus_volt < safe_limit;
        cond.bus_ok   = bus_volt >= arm_ref;
    end
endmodule

// File: rtl/dcfrt_window.sv
module dcfrt_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] length,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] eff_len;

    always_comb begin
        eff_len = (length == '0) ? ONE : length;
        last    = (cnt + ONE) >= eff_len;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && !last) begin
            cnt <= cnt + ONE;
        end
    end
endmodule

// File: rtl/dcfrt_fsm.sv
module dcfrt_fsm
    import dcfrt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frt_cond_t  cond,
    input  logic       win_last,
    output frt_state_t state,
    output logic       win_clr,
    output logic       win_inc
);
    frt_state_t nxt;

    always_comb begin
        nxt = state;
        if (tick) begin
            unique case (state)
                ST_NORMAL:  if (cond.over_cur) nxt = ST_BLOCKED;
                ST_BLOCKED: if (cond.bus_low)  nxt = ST_ARMING;
                ST_ARMING:  nxt = ST_FAULT;
                ST_FAULT:   if (win_last)      nxt = ST_ISOLATE;
                ST_ISOLATE: begin
                    if (cond.over_cur)    nxt = ST_BLOCKED;
                    else if (cond.bus_ok) nxt = ST_NORMAL;
                end
                default:    nxt = ST_BLOCKED;
            endcase
        end
    end

    always_comb begin
        win_clr = (state != ST_FAULT);
        win_inc = (state == ST_FAULT) && tick;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_NORMAL;
        else     state <= nxt;
    end
endmodule

// File: rtl/dcfrt_seq.sv
module dcfrt_seq
    import dcfrt_pkg::*;
#(
    parameter int CUR_W  = 12,
    parameter int VOLT_W = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              period_tick,
    input  logic [CUR_W-1:0]  dc_current,
    input  logic [VOLT_W-1:0] bus_volt,
    input  logic [CUR_W-1:0]  oc_limit,
    input  logic [VOLT_W-1:0] safe_limit,
    input  logic [CNT_W-1:0]  fault_periods,
    input  logic [VOLT_W-1:0] arm_ref,
    output logic              gate_en,
    output logic              fault_mode,
    output logic              duty_ctrl_cur,
    output logic [2:0]        state_code
);
    frt_cond_t  cond;
    frt_state_t state;
    frt_ctrl_t  ctrl;
    logic       win_clr;
    logic       win_inc;
    logic       win_last;

    dcfrt_cond #(.CUR_W(CUR_W), .VOLT_W(VOLT_W)) u_cond (
        .dc_current (dc_current),
        .bus_volt   (bus_volt),
        .oc_limit   (oc_limit),
        .safe_limit (safe_limit),
        .arm_ref    (arm_ref),
        .cond       (cond)
    );

    dcfrt_window #(.CNT_W(CNT_W)) u_win (
        .clk    (clk),
        .rst    (rst),
        .clr    (win_clr),
        .inc    (win_inc),
        .length (fault_periods),
        .last   (win_last)
    );

    dcfrt_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (period_tick),
        .cond     (cond),
        .win_last (win_last),
        .state    (state),
        .win_clr  (win_clr),
        .win_inc  (win_inc)
    );

    always_comb begin
        ctrl          = ctrl_of(state);
        gate_en       = ctrl.gate_en;
        fault_mode    = ctrl.fault_mode;
        duty_ctrl_cur = ctrl.duty_ctrl_cur;
        state_code    = state;
    end
endmodule

// File: rtl/dcfrt_chk.sv
module dcfrt_chk #(
    parameter int CUR_W  = 12,
    parameter int VOLT_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              period_tick,
    input logic [CUR_W-1:0]  dc_current,
    input logic [VOLT_W-1:0] bus_volt,
    input logic [CUR_W-1:0]  oc_limit,
    input logic [VOLT_W-1:0] safe_limit,
    input logic [VOLT_W-1:0] arm_ref,
    input logic              gate_en,
    input logic              fault_mode,
    input logic              duty_ctrl_cur,
    input logic [2:0]        state_code
);
    a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !period_tick |=> $stable(state_code));

    a_r2_trip: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd0 && period_tick && dc_current > oc_limit)
        |=> (state_code == 3'd1 && !gate_en));

    a_r4_wait_collapse: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd1 && !(period_tick && bus_volt < safe_limit))
        |=> state_code == 3'd1);

    a_r5_arm_one_period: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd2 && period_tick) |=> (state_code == 3'd3 && fault_mode));

    a_r7_recover: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd4 && period_tick && dc_current <= oc_limit && bus_volt >= arm_ref)
        |=> state_code == 3'd0);

    a_r8_retrip: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd4 && period_tick && dc_current > oc_limit)
        |=> state_code == 3'd1);

    a_r10_gate_states: assert property (@(posedge clk) disable iff (rst)
        gate_en |-> (state_code == 3'd0 || state_code == 3'd3));

    a_r10_mode_pair: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_mode) |-> ($past(state_code) == 3'd2 && duty_ctrl_cur));
endmodule

bind dcfrt_seq dcfrt_chk #(.CUR_W(CUR_W), .VOLT_W(VOLT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .period_tick   (period_tick),
    .dc_current    (dc_current),
    .bus_volt      (bus_volt),
    .oc_limit      (oc_limit),
    .safe_limit    (safe_limit),
    .arm_ref       (arm_ref),
    .gate_en       (gate_en),
    .fault_mode    (fault_mode),
    .duty_ctrl_cur (duty_ctrl_cur),
    .state_code    (state_code)
);

// File: tb/sim_dcfrt_seq.sv
module sim_dcfrt_seq;
    localparam int CW = 12;
    localparam int VW = 12;
    localparam int NW = 16;
    localparam int OC = 180;
    localparam int SAFE = 25;
    localparam int ARM = 250;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [CW-1:0] cur = '0;
    logic [VW-1:0] volt = VW'(ARM);
    logic [CW-1:0] oc_lim = CW'(OC);
    logic [VW-1:0] safe_lim = VW'(SAFE);
    logic [NW-1:0] nper = NW'(3);
    logic [VW-1:0] arm = VW'(ARM);
    logic          gate_en, fault_mode, duty_cur;
    logic [2:0]    code;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    dcfrt_seq #(.CUR_W(CW), .VOLT_W(VW), .CNT_W(NW)) u0 (
        .clk(clk), .rst(rst), .period_tick(tick), .dc_current(cur), .bus_volt(volt),
        .oc_limit(oc_lim), .safe_limit(safe_lim), .fault_periods(nper), .arm_ref(arm),
        .gate_en(gate_en), .fault_mode(fault_mode), .duty_ctrl_cur(duty_cur), .state_code(code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int c, input int v);
        @(negedge clk);
        cur = CW'(c); volt = VW'(v); tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic check_outs(input string req, input int exp_code);
        check({req, " code"}, int'(code), exp_code);
        check({req, " gate"}, int'(gate_en), (exp_code == 0 || exp_code == 3) ? 1 : 0);
        check({req, " mode"}, int'(fault_mode), (exp_code == 3) ? 1 : 0);
        check({req, " duty"}, int'(duty_cur), (exp_code == 3) ? 1 : 0);
    endtask

    // trip, collapse, arm: leaves block in fault-current phase
    task automatic into_fault();
        strobe(OC + 1, ARM);
        strobe(OC + 1, 0);
        strobe(OC + 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_outs("R9 reset", 0);

        // R3/R2: current sweep across the threshold
        for (int c = OC - 3; c <= OC + 2; c++) begin
            do_reset();
            strobe(c, ARM);
            check_outs((c > OC) ? "R2 trip" : "R3 no trip", (c > OC) ? 1 : 0);
        end

        // R1: over-limit samples without strobe are ignored
        do_reset();
        @(negedge clk); cur = CW'(OC + 50); volt = '0;
        repeat (6) @(negedge clk);
        check_outs("R1 no strobe", 0);

        // R4: voltage sweep around the safe threshold
        for (int v = SAFE + 2; v >= SAFE - 1; v--) begin
            do_reset();
            strobe(OC + 1, ARM);
            strobe(0, v);
            check_outs("R4 collapse", (v < SAFE) ? 2 : 1);
        end

        // R5: arming lasts one strobe; R1 inside blocked state
        do_reset();
        strobe(OC + 1, ARM);
        @(negedge clk); volt = '0; repeat (4) @(negedge clk);
        check_outs("R1 blocked hold", 1);
        strobe(0, 0);
        check_outs("R5 arming", 2);
        strobe(0, 0);
        check_outs("R5 fault entry", 3);

        // R6: window length sweep, overcurrent present throughout
        for (int n = 0; n <= 5; n++) begin
            int cnt;
            nper = NW'(n);
            do_reset();
            into_fault();
            cnt = 0;
            while (code == 3 && cnt < 20) begin
                strobe(OC + 40, 0);
                cnt++;
            end
            check("R6 window length", cnt, (n == 0) ? 1 : n);
            check_outs("R6 isolate", 4);
        end
        nper = NW'(3);

        // R7: recovery voltage sweep
        for (int v = ARM - 2; v <= ARM + 1; v++) begin
            do_reset();
            into_fault();
            repeat (3) strobe(0, 0);
            strobe(OC, v);
            check_outs("R7 recovery", (v >= ARM) ? 0 : 4);
        end

        // R8: overcurrent with recovered bus during isolation
        do_reset();
        into_fault();
        repeat (3) strobe(0, 0);
        check_outs("R8 pre", 4);
        strobe(OC + 1, ARM + 10);
        check_outs("R8 retrip", 1);
        strobe(0, 0);
        check_outs("R8 sequence restarts", 2);

        // R10: full cycle back to normal, then a second trip
        strobe(0, 0);
        check_outs("R10 fault", 3);
        repeat (3) strobe(0, 100);
        check_outs("R10 isolate", 4);
        strobe(0, ARM);
        check_outs("R10 normal", 0);
        strobe(OC + 7, ARM);
        check_outs("R10 second trip", 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule